// File: doc/BRIEF.md
# Ethernet Specific Address Filter

This block decides whether an incoming Ethernet frame is addressed to the local station. It holds four programmable 48-bit station addresses, called slots, and compares the destination field of each frame against them. The frame arrives as a byte stream with a start-of-frame strobe. Software programs the slots through a 32-bit word-addressed write/read port. Each slot has an activation flag that software controls as a side effect of its writes. Writing the low word of a slot takes it out of service. Writing the high word puts it back in service, so a slot is always re-armed only after both halves hold a consistent address.

As the first six bytes stream in, every slot runs its own byte-serial compare. So does a fixed all-ones lane for broadcast. At the start of each frame, each slot takes a private copy of its address and its flag. After the sixth byte the block gives a single-cycle result. A hit on an active slot wins first, and the highest slot index has priority. Next comes a broadcast hit. Otherwise the frame is a miss.

The sequencer has three states: `ST_IDLE` (no frame yet), `ST_ADDR` (destination bytes two to six being compared) and `ST_DRAIN` (result given, payload bytes ignored). The transitions are:
- *start*: a start-of-frame byte moves the block from any state into `ST_ADDR`.
- *finish*: the sixth byte in `ST_ADDR` moves it to `ST_DRAIN` and issues the result.
- *hold*: in any other case the state stays as it is.

Top module: `eaf_addr_filter`

## Requirements
- R1: Register word 2s is the low half of slot s and word 2s+1 is its high half (byte offsets 8s and 8s+4). A read returns the last value written to that word, all 32 bits, whatever the slot's activation flag.
- R2: A write to a slot's low word stores the data and clears that slot's activation flag from the next cycle on.
- R3: A write to a slot's high word stores the data and sets that slot's activation flag from the next cycle on.
- R4: Reset clears all activation flags and all stored words to zero.
- R5: Only the first six frame bytes are compared. The first byte received is compared with low-word bits 7:0, and bytes 2 to 4 with the higher bytes of the low word. Bytes 5 and 6 are compared with high-word bits 7:0 and 15:8. High-word bits 31:16 play no part in matching.
- R6: A slot can match only while its flag is set. When several active slots match, the highest slot index is reported.
- R7: The result is broadcast when no active slot matches and all six destination bytes are 0xFF. An active slot that matches an all-ones address takes precedence and is reported as a match.
- R8: The result is a one-cycle `res_valid` pulse in the cycle after the sixth byte is accepted. With it, exactly one of `res_match`, `res_bcast` and `res_miss` is set. `res_slot` carries the slot index on a match and 0 otherwise. All result outputs are 0 when `res_valid` is low.
- R9: A start-of-frame byte always restarts the compare, also in the middle of a destination field, and an interrupted frame gives no result. Bytes after the sixth, and bytes with `rx_valid` low, have no effect.
- R10: A slot write issued while a frame's destination is being compared, or in the same cycle as its start-of-frame byte, does not change that frame's result. It applies to frames that start later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the word at `reg_word` (combinational) |
| rx_valid | input | 1 | Frame byte valid |
| rx_sof | input | 1 | First byte of a frame (qualified by `rx_valid`) |
| rx_data | input | 8 | Frame byte |
| res_valid | output | 1 | One-cycle result pulse |
| res_match | output | 1 | An active slot matched |
| res_bcast | output | 1 | Broadcast destination |
| res_miss | output | 1 | No slot and no broadcast |
| res_slot | output | 2 | Index of the matching slot |

## Verification
The assertions assume that `rx_sof` matters only together with `rx_valid`. They also assume that frames are far enough apart for results to come as isolated pulses, so no two results fall in back-to-back cycles. The stimulus meets both assumptions: every start-of-frame strobe goes out with a valid byte, and each result needs at least six accepted bytes. The stimulus also reaches the cases where the assumptions matter most: idle gaps between bytes, frames cut off and restarted before their sixth byte, bytes trailing after the destination, and a slot write landing in the middle of a frame.

// File: rtl/eaf_pkg.sv
package eaf_pkg;
    localparam int MAC_BYTES = 6;
    localparam int MAC_W     = 8 * MAC_BYTES;
    localparam int BYTE_IX_W = $clog2(MAC_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_DRAIN = 2'd2
    } eaf_state_e;
endpackage

// File: rtl/eaf_slot_regs.sv
module eaf_slot_regs #(
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int WORD_W   = SEL_W + 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [WORD_W-1:0]                 word,
    input  logic [31:0]                       wdata,
    output logic [31:0]                       rdata,
    output logic [NUM_SLOTS-1:0][eaf_pkg::MAC_W-1:0] slot_mac,
    output logic [NUM_SLOTS-1:0]              slot_act
);
    logic [NUM_SLOTS-1:0][31:0] lo_q;
    logic [NUM_SLOTS-1:0][31:0] hi_q;
    logic [NUM_SLOTS-1:0]       act_q;
    logic [SEL_W-1:0]           sel;
    logic                       upper;

    assign sel   = word[WORD_W-1:1];
    assign upper = word[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            act_q <= '0;
        end else if (wr_en) begin
            if (upper) begin
                hi_q[sel]  <= wdata;
                act_q[sel] <= 1'b1;
            end else begin
                lo_q[sel]  <= wdata;
                act_q[sel] <= 1'b0;
            end
        end
    end

    assign rdata    = upper ? hi_q[sel] : lo_q[sel];
    assign slot_act = act_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mac
        assign slot_mac[i] = {hi_q[i][15:0], lo_q[i]};
    end
endmodule

// File: rtl/eaf_cmp_lane.sv
module eaf_cmp_lane (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            step,
    input  logic [eaf_pkg::BYTE_IX_W-1:0]   byte_ix,
    input  logic [7:0]                      data,
    input  logic [eaf_pkg::MAC_W-1:0]       mac,
    input  logic                            act,
    output logic                            hit_now
);
    logic [eaf_pkg::MAC_W-1:0] snap_mac;
    logic                      snap_act;
    logic                      run_q;
    logic                      byte_eq;

    assign byte_eq = (data == snap_mac[byte_ix*8 +: 8]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_mac <= '0;
            snap_act <= 1'b0;
            run_q    <= 1'b0;
        end else if (start) begin
            snap_mac <= mac;
            snap_act <= act;
            run_q    <= (data == mac[7:0]);
        end else if (step) begin
            run_q <= run_q & byte_eq;
        end
    end

    assign hit_now = snap_act & run_q & byte_eq;
endmodule

// File: rtl/eaf_prio.sv
module eaf_prio #(
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] hits,
    input  logic                 bcast_hit,
    output logic                 is_match,
    output logic                 is_bcast,
    output logic                 is_miss,
    output logic [SEL_W-1:0]     idx
);
    always_comb begin
        is_match = 1'b0;
        idx      = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hits[i]) begin
                is_match = 1'b1;
                idx      = SEL_W'(i);
            end
        end
        is_bcast = !is_match && bcast_hit;
        is_miss  = !is_match && !bcast_hit;
    end
endmodule

// File: rtl/eaf_addr_filter.sv
module eaf_addr_filter #(
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int WORD_W   = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_word,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_data,
    output logic              res_valid,
    output logic              res_match,
    output logic              res_bcast,
    output logic              res_miss,
    output logic [SEL_W-1:0]  res_slot
);
    import eaf_pkg::*;

    localparam logic [BYTE_IX_W-1:0] LAST_IX = BYTE_IX_W'(MAC_BYTES - 1);

    logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_mac;
    logic [NUM_SLOTS-1:0]            slot_act;
    logic [NUM_SLOTS-1:0]            slot_hit;
    logic                            bc_hit;

    eaf_state_e             state_q, state_d;
    logic [BYTE_IX_W-1:0]   byte_q;
    logic                   start, step, last;
    logic                   p_match, p_bcast, p_miss;
    logic [SEL_W-1:0]       p_idx;

    eaf_slot_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .word     (reg_word),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .slot_mac (slot_mac),
        .slot_act (slot_act)
    );

    assign start = rx_valid && rx_sof;
    assign step  = rx_valid && !rx_sof && (state_q == ST_ADDR);
    assign last  = step && (byte_q == LAST_IX);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_lane
        eaf_cmp_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start),
            .step    (step),
            .byte_ix (byte_q),
            .data    (rx_data),
            .mac     (slot_mac[i]),
            .act     (slot_act[i]),
            .hit_now (slot_hit[i])
        );
    end

    eaf_cmp_lane u_bc_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .step    (step),
        .byte_ix (byte_q),
        .data    (rx_data),
        .mac     ({MAC_W{1'b1}}),
        .act     (1'b1),
        .hit_now (bc_hit)
    );

    eaf_prio #(.NUM_SLOTS(NUM_SLOTS)) u_prio (
        .hits      (slot_hit),
        .bcast_hit (bc_hit),
        .is_match  (p_match),
        .is_bcast  (p_bcast),
        .is_miss   (p_miss),
        .idx       (p_idx)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ADDR;
            ST_ADDR:  begin
                if (start)     state_d = ST_ADDR;
                else if (last) state_d = ST_DRAIN;
            end
            ST_DRAIN: if (start) state_d = ST_ADDR;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and byte position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start)     byte_q <= BYTE_IX_W'(1);
            else if (step) byte_q <= byte_q + 1'b1;
        end
    end

    // registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
            res_bcast <= 1'b0;
            res_miss  <= 1'b0;
            res_slot  <= '0;
        end else begin
            res_valid <= last;
            res_match <= last && p_match;
            res_bcast <= last && p_bcast;
            res_miss  <= last && p_miss;
            res_slot  <= last ? p_idx : '0;
        end
    end
endmodule

// File: rtl/eaf_chk.sv
module eaf_chk #(
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS),
    localparam int WORD_W   = SEL_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_word,
    input logic              rx_valid,
    input logic              rx_sof,
    input logic              res_valid,
    input logic              res_match,
    input logic              res_bcast,
    input logic              res_miss,
    input logic [SEL_W-1:0]  res_slot,
    input logic [NUM_SLOTS-1:0] slot_act
);
    logic             wlo_q, whi_q;
    logic [SEL_W-1:0] wsel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlo_q  <= 1'b0;
            whi_q  <= 1'b0;
            wsel_q <= '0;
        end else begin
            wlo_q  <= reg_wr && !reg_word[0];
            whi_q  <= reg_wr && reg_word[0];
            wsel_q <= reg_word[WORD_W-1:1];
        end
    end

    assert_lo_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wlo_q |-> !slot_act[wsel_q]);

    assert_hi_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        whi_q |-> slot_act[wsel_q]);

    assert_one_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones({res_match, res_bcast, res_miss}) == 1));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ({res_match, res_bcast, res_miss} == 3'b000 && res_slot == '0));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> ($past(rx_valid) && !$past(rx_sof)));

    assert_slot_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_match) |-> (res_slot == '0));
endmodule

bind eaf_addr_filter eaf_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_word  (reg_word),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .res_valid (res_valid),
    .res_match (res_match),
    .res_bcast (res_bcast),
    .res_miss  (res_miss),
    .res_slot  (res_slot),
    .slot_act  (slot_act)
);

// File: tb/eaf_addr_filter_tb.sv
module eaf_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_word = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        res_valid, res_match, res_bcast, res_miss;
    logic [1:0]  res_slot;

    int n_checks = 0;
    int n_fail   = 0;
    bit summary_done = 0;

    logic [31:0] m_lo [4];
    logic [31:0] m_hi [4];
    bit          m_act [4];

    logic [4:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    eaf_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_data(rx_data), .res_valid(res_valid),
        .res_match(res_match), .res_bcast(res_bcast), .res_miss(res_miss),
        .res_slot(res_slot)
    );

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // encoding {match, bcast, miss, slot[1:0]}
    function automatic logic [4:0] predict(logic [47:0] dst);
        for (int s = 3; s >= 0; s--)
            if (m_act[s] && {m_hi[s][15:0], m_lo[s]} == dst) return {3'b100, 2'(s)};
        if (dst == '1) return 5'b01000;
        return 5'b00100;
    endfunction

    function automatic void model_write(int w, logic [31:0] d);
        if (w % 2 == 1) begin m_hi[w/2] = d; m_act[w/2] = 1; end
        else            begin m_lo[w/2] = d; m_act[w/2] = 0; end
    endfunction

    task automatic reg_write(int w, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = 3'(w); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(w, d);
    endtask

    task automatic check_read(int w, logic [31:0] exp, string req);
        @(negedge clk);
        reg_word = 3'(w);
        #1;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    // drives n bytes of a frame (n may exceed 6); optional write at byte wr_at
    task automatic drive(logic [47:0] dst, int n, bit gap, int wr_at, int w, logic [31:0] d);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (k == 0);
            rx_data  = (k < 6) ? dst[8*k +: 8] : 8'(k * 17);
            if (k == wr_at) begin
                reg_wr = 1'b1; reg_word = 3'(w); reg_wdata = d;
            end
            if (gap) begin
                @(negedge clk);
                if (k == wr_at) begin reg_wr = 1'b0; model_write(w, d); end
                rx_valid = 1'b0; rx_sof = 1'b0; rx_data = 8'hA5;
            end
        end
        @(negedge clk);
        if (!gap && wr_at >= 0 && wr_at < n) model_write(w, d);
        reg_wr = 1'b0;
        rx_valid = 1'b0; rx_sof = 1'b0;
    endtask

    task automatic send(logic [47:0] dst, int n, bit gap, string req);
        exp_q.push_back(predict(dst));
        tag_q.push_back(req);
        drive(dst, n, gap, -1, 0, 0);
    endtask

    // monitor
    always @(posedge clk) begin
        #5;
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected result", 32'({res_match, res_bcast, res_miss, res_slot}), 0);
            end else begin
                logic [4:0] e;
                logic [4:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {res_match, res_bcast, res_miss, res_slot};
                check(a === e, t, 32'(a), 32'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        for (int s = 0; s < 4; s++) begin m_lo[s] = 0; m_hi[s] = 0; m_act[s] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state
        check_read(0, 32'h0, "R4 lo0 after reset");
        check_read(7, 32'h0, "R4 hi3 after reset");
        send(48'h0, 6, 0, "R4 flags cleared -> miss");

        // R5 byte order and R1 read-back
        reg_write(0, 32'h44332211);
        reg_write(1, 32'hABCD6655);
        check_read(1, 32'hABCD6655, "R1 hi0 readback");
        check_read(0, 32'h44332211, "R1 lo0 readback");
        send(48'h665544332211, 6, 0, "R5 match slot0 upper bits ignored");
        send(48'h665544332212, 6, 0, "R5 first byte differs -> miss");
        send(48'h675544332211, 6, 0, "R5 sixth byte differs -> miss");
        send(48'h112233445566, 6, 0, "R5 reversed order -> miss");

        // R6 priority
        reg_write(4, 32'h0A0B0C0D);
        reg_write(5, 32'h00000E0F);
        reg_write(6, 32'h0A0B0C0D);
        reg_write(7, 32'h00000E0F);
        send(48'h0E0F0A0B0C0D, 6, 0, "R6 slot3 wins over slot2");

        // R2 disable by low write, R1 read regardless of flag
        reg_write(6, 32'h0A0B0C0D);
        check_read(6, 32'h0A0B0C0D, "R1 lo3 readback while inactive");
        send(48'h0E0F0A0B0C0D, 6, 0, "R2 slot3 off -> slot2");
        reg_write(4, 32'h0A0B0C0D);
        send(48'h0E0F0A0B0C0D, 6, 0, "R2 both off -> miss");
        // R3 re-enable
        reg_write(5, 32'h00000E0F);
        send(48'h0E0F0A0B0C0D, 6, 1, "R3 slot2 back on with gaps");

        // R7 broadcast
        send(48'hFFFFFFFFFFFF, 6, 0, "R7 broadcast");
        reg_write(2, 32'hFFFFFFFF);
        reg_write(3, 32'h0000FFFF);
        send(48'hFFFFFFFFFFFF, 6, 0, "R7 slot1 all ones beats broadcast");
        send(48'hFFFFFFFFFFFE, 6, 0, "R7 near-broadcast -> miss");

        // R9 restart and trailing bytes
        drive(48'h665544332211, 3, 0, -1, 0, 0);
        send(48'h0E0F0A0B0C0D, 6, 0, "R9 restart after partial");
        send(48'h665544332211, 12, 0, "R9 trailing bytes ignored");
        drive(48'h665544332211, 5, 1, -1, 0, 0);
        send(48'hFFFFFFFFFFFF, 9, 1, "R9 restart after five bytes");

        // R10 write during compare
        exp_q.push_back(predict(48'h665544332211));
        tag_q.push_back("R10 mid-frame disable not seen");
        drive(48'h665544332211, 6, 0, 2, 0, 32'h44332211);
        send(48'h665544332211, 6, 0, "R10 next frame sees disable");
        exp_q.push_back(predict(48'h665544332211));
        tag_q.push_back("R10 write with sof not seen");
        drive(48'h665544332211, 6, 0, 0, 1, 32'h00006655);
        send(48'h665544332211, 6, 0, "R10 next frame sees enable");

        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
        summary();
    end
endmodule